// File: doc/BRIEF.md
# Field Length Meter with Doubled-Rate Vertical Sync

This block watches the vertical sync of an incoming video stream and measures how long each field lasts, in units of half a line. The sync input is not sampled on every clock. It is sampled only on an internal strobe that fires once per half-line period. The phase of that strobe within the half-line is set by an input, so the sampling point can be moved away from the instants where the incoming sync changes. The two most recent field lengths are held in a pair of registers that a controller can read.

From the position inside the current field and the last measured length, the block produces a display vertical sync at twice the input field rate. The first pulse comes a programmable number of half-lines after the input field boundary. The second comes half a measured field later. Two field-identity flags toggle: one at each input field boundary and one at each doubled-rate sync pulse.

A scan-rate converter uses the block to time its display fields against the acquired fields. Firmware reads the measured lengths to choose its display settings.

Top module: `field_rate_doubler`

## Requirements
- R1: While `rst` is high and on the first clock after it, `halfline_strobe`, `vsync_dbl`, `field_id_in`, `field_id_dbl`, `field_len_last` and `field_len_prev` are all 0.
- R2: `halfline_strobe` is a one-clock pulse every HALF_CYC clocks. It is high in the clock after the internal half-line cycle counter (0 after reset, wrapping at HALF_CYC-1) equals `strobe_phase`.
- R3: `vsync_in` is looked at only on clocks where the strobe is high. A pulse that starts and ends between two strobes changes neither the field count nor any output.
- R4: A field boundary is a strobe at which `vsync_in` is 1 while the value sampled at the previous strobe was 0. A sync held high across many strobes makes one boundary only.
- R5: At a boundary, `field_len_last` takes the number of strobes since the previous boundary, counting the current one. In the same clock `field_len_prev` takes the old `field_len_last`.
- R6: The field count saturates at 2^LEN_W-1 (1023 by default) and does not wrap when no boundary arrives.
- R7: `field_id_in` inverts in the clock after each boundary and at no other time.
- R8: `vsync_dbl` is a one-clock pulse in the clock after a strobe whose position equals `sync_offset`. Position 0 is the boundary strobe, and each later strobe adds 1.
- R9: `vsync_dbl` also pulses after the strobe whose position equals `sync_offset` plus floor(`field_len_last`/2). Here `field_len_last` is its value before that strobe.
- R10: `field_id_dbl` inverts in the same clock as each `vsync_dbl` pulse and at no other time.
- R11: Once the position has saturated, later strobes give no `vsync_dbl` pulse until the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_in | input | 1 | Incoming vertical sync, active high |
| strobe_phase | input | PW | Strobe position within the half-line, in clocks |
| sync_offset | input | LEN_W | Delay from boundary to first doubled sync, in half-lines |
| halfline_strobe | output | 1 | Half-line sampling strobe |
| field_len_last | output | LEN_W | Length of the most recent field |
| field_len_prev | output | LEN_W | Length of the field before it |
| vsync_dbl | output | 1 | Doubled-rate vertical sync pulse |
| field_id_in | output | 1 | Input-rate field identity |
| field_id_dbl | output | 1 | Doubled-rate field identity |

## Verification
The hardest case to reach is saturation. Getting there needs a field longer than 1023 half-lines, which is about 16,000 clocks with the bench's strobe period of 16 clocks. The stimulus holds the sync low for 1100 strobes with the offset set to the saturation value. That one stretch shows the clamped length, a single pulse at the clamp point, and silence after it. Sync pulses placed between two strobes, and a sync held high for many strobes, are steered from the observed strobe output. This lets them land exactly inside or across sampling points.

// File: rtl/fvd_pkg.sv
package fvd_pkg;
  localparam int LEN_W_DEF    = 10;
  localparam int HALF_CYC_DEF = 864;
endpackage

// File: rtl/fvd_strobe_gen.sv
module fvd_strobe_gen #(
  parameter int HALF_CYC = 864,
  parameter int PW       = $clog2(HALF_CYC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] phase,
  output logic          strobe
);
  localparam logic [PW-1:0] LAST = PW'(HALF_CYC - 1);

  logic [PW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt   <= '0;
      strobe <= 1'b0;
    end else begin
      hcnt   <= (hcnt == LAST) ? '0 : hcnt + 1'b1;
      strobe <= (hcnt == phase);
    end
  end

  // R2: a strobe is never followed by another strobe in the next clock
  a_r2_strobe_gap: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
endmodule

// File: rtl/fvd_field_meter.sv
module fvd_field_meter #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             vs_in,
  output logic             bnd,
  output logic [LEN_W-1:0] pos,
  output logic [LEN_W-1:0] len_last,
  output logic [LEN_W-1:0] len_prev,
  output logic             fid_in
);
  localparam logic [LEN_W-1:0] MAXV = '1;

  logic             s_last;
  logic [LEN_W-1:0] pos_inc;
  logic             pv;

  always_comb begin
    bnd     = strobe && vs_in && !s_last;
    pos_inc = (pos == MAXV) ? MAXV : pos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_last   <= 1'b0;
      pos      <= '0;
      len_last <= '0;
      len_prev <= '0;
      fid_in   <= 1'b0;
      pv       <= 1'b0;
    end else begin
      pv <= 1'b1;
      if (strobe) begin
        s_last <= vs_in;
        if (bnd) begin
          len_prev <= len_last;
          len_last <= pos_inc;
          pos      <= '0;
          fid_in   <= ~fid_in;
        end else begin
          pos <= pos_inc;
        end
      end
    end
  end

  // R3: the count moves only after a strobe
  a_r3_count_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (pv && !$past(strobe)) |-> $stable(pos));
  // R5: the older register only ever takes the newer one
  a_r5_shift_pair: assert property (@(posedge clk) disable iff (rst)
    (pv && (len_prev != $past(len_prev))) |-> (len_prev == $past(len_last)));
  // R6: a full count stays full without a boundary
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(pos) == MAXV && !$past(bnd)) |-> (pos == MAXV));
  // R7: the input field flag moves only on a boundary
  a_r7_fid_on_bnd: assert property (@(posedge clk) disable iff (rst)
    (pv && (fid_in != $past(fid_in))) |-> $past(bnd));
endmodule

// File: rtl/fvd_vsync_dbl.sv
module fvd_vsync_dbl #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             bnd,
  input  logic [LEN_W-1:0] pos,
  input  logic [LEN_W-1:0] len_last,
  input  logic [LEN_W-1:0] offset,
  output logic             vs_out,
  output logic             fid_dbl
);
  localparam logic [LEN_W-1:0] MAXV = '1;

  logic [LEN_W-1:0] cur;
  logic [LEN_W:0]   tgt1, tgt2;
  logic             frozen, hit, pv;

  always_comb begin
    frozen = (pos == MAXV) && !bnd;
    if (bnd)               cur = '0;
    else if (pos == MAXV)  cur = MAXV;
    else                   cur = pos + 1'b1;
    tgt1 = {1'b0, offset};
    tgt2 = {1'b0, offset} + {2'b00, len_last[LEN_W-1:1]};
    hit  = strobe && !frozen && (({1'b0, cur} == tgt1) || ({1'b0, cur} == tgt2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_out  <= 1'b0;
      fid_dbl <= 1'b0;
      pv      <= 1'b0;
    end else begin
      pv     <= 1'b1;
      vs_out <= hit;
      if (hit) fid_dbl <= ~fid_dbl;
    end
  end

  // R8: a doubled sync pulse always follows a strobe
  a_r8_after_strobe: assert property (@(posedge clk) disable iff (rst)
    (pv && vs_out) |-> $past(strobe));
  // R10: each pulse flips the doubled-rate flag
  a_r10_fid_flip: assert property (@(posedge clk) disable iff (rst)
    (pv && vs_out) |-> (fid_dbl != $past(fid_dbl)));
  // R11: no pulse while the position sits at saturation
  a_r11_quiet_sat: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(pos) == MAXV && !$past(bnd)) |-> !vs_out);
endmodule

// File: rtl/field_rate_doubler.sv
module field_rate_doubler
  import fvd_pkg::*;
#(
  parameter int HALF_CYC = HALF_CYC_DEF,
  parameter int LEN_W    = LEN_W_DEF,
  parameter int PW       = $clog2(HALF_CYC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vsync_in,
  input  logic [PW-1:0]    strobe_phase,
  input  logic [LEN_W-1:0] sync_offset,
  output logic             halfline_strobe,
  output logic [LEN_W-1:0] field_len_last,
  output logic [LEN_W-1:0] field_len_prev,
  output logic             vsync_dbl,
  output logic             field_id_in,
  output logic             field_id_dbl
);
  logic             strobe;
  logic             bnd;
  logic [LEN_W-1:0] pos;

  fvd_strobe_gen #(.HALF_CYC(HALF_CYC), .PW(PW)) u_strobe (
    .clk(clk), .rst(rst), .phase(strobe_phase), .strobe(strobe)
  );

  fvd_field_meter #(.LEN_W(LEN_W)) u_meter (
    .clk(clk), .rst(rst), .strobe(strobe), .vs_in(vsync_in),
    .bnd(bnd), .pos(pos), .len_last(field_len_last),
    .len_prev(field_len_prev), .fid_in(field_id_in)
  );

  fvd_vsync_dbl #(.LEN_W(LEN_W)) u_dbl (
    .clk(clk), .rst(rst), .strobe(strobe), .bnd(bnd), .pos(pos),
    .len_last(field_len_last), .offset(sync_offset),
    .vs_out(vsync_dbl), .fid_dbl(field_id_dbl)
  );

  assign halfline_strobe = strobe;
endmodule

// File: tb/tb_field_rate_doubler.sv
module tb_field_rate_doubler;
  localparam int HC   = 16;
  localparam int PW   = 4;
  localparam int LW   = 10;
  localparam int MAXL = 1023;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vin = 1'b0;
  logic [PW-1:0] phase = 4'd5;
  logic [LW-1:0] off = '0;
  logic          strb, vsd, fidi, fidd;
  logic [LW-1:0] llast, lprev;

  field_rate_doubler #(.HALF_CYC(HC), .LEN_W(LW), .PW(PW)) dut (
    .clk(clk), .rst(rst), .vsync_in(vin), .strobe_phase(phase),
    .sync_offset(off), .halfline_strobe(strb), .field_len_last(llast),
    .field_len_prev(lprev), .vsync_dbl(vsd), .field_id_in(fidi),
    .field_id_dbl(fidd)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, npulse = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  // behavioural reference, in strobes and half-lines
  int m_h, m_pos, m_ll, m_lp;
  bit m_strb, m_slast, m_fid, m_vs, m_fd;
  always @(posedge clk) begin
    bit sn, edge_now, hit;
    int cur, oll;
    if (rst) begin
      m_h = 0; m_pos = 0; m_ll = 0; m_lp = 0;
      m_strb = 0; m_slast = 0; m_fid = 0; m_vs = 0; m_fd = 0;
    end else begin
      sn = m_strb;
      edge_now = sn && vin && !m_slast;
      oll = m_ll;
      m_strb = (m_h == int'(phase));
      m_h = (m_h == HC - 1) ? 0 : m_h + 1;
      cur = edge_now ? 0 : ((m_pos + 1 > MAXL) ? MAXL : m_pos + 1);
      hit = sn && !(m_pos == MAXL && !edge_now) &&
            (cur == int'(off) || cur == int'(off) + oll / 2);
      m_vs = hit;
      if (hit) m_fd = !m_fd;
      if (sn) begin
        m_slast = vin;
        if (edge_now) begin
          m_lp = m_ll; m_ll = cur == 0 ? ((m_pos + 1 > MAXL) ? MAXL : m_pos + 1) : 0;
          m_fid = !m_fid;
        end
        m_pos = cur;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(int'(strb), int'(m_strb), "R2 halfline_strobe");
      chk(int'(llast), m_ll, "R5 field_len_last");
      chk(int'(lprev), m_lp, "R5 field_len_prev");
      chk(int'(fidi), int'(m_fid), "R7 field_id_in");
      chk(int'(vsd), int'(m_vs), "R8 R9 vsync_dbl");
      chk(int'(fidd), int'(m_fd), "R10 field_id_dbl");
      if (vsd) npulse++;
    end
  end

  task automatic wait_strobe();
    do @(negedge clk); while (!strb);
  endtask

  // one field of n strobes; sync high for h strobes; optional glitch;
  // when chk_len, verifies the lengths captured at this field's boundary
  task automatic field(input int n, input int h, input bit glitch,
                       input bit chk_len, input int e_last, input int e_prev);
    vin = 1'b1;
    wait_strobe();
    if (chk_len) begin
      chk(int'(llast), e_last, "R5 length of last field");
      chk(int'(lprev), e_prev, "R5 length of previous field");
    end
    for (int i = 1; i < h; i++) wait_strobe();
    vin = 1'b0;
    for (int i = h; i < n; i++) begin
      wait_strobe();
      if (glitch && i == h + 5) begin
        bit f0 = fidi;
        @(negedge clk); vin = 1'b1;
        repeat (4) @(negedge clk);
        vin = 1'b0;
        wait_strobe(); i++;
        chk(int'(fidi), int'(f0), "R3 glitch between strobes ignored");
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0, fid0;
    repeat (3) @(negedge clk);
    chk(int'(strb), 0, "R1 strobe in reset");
    chk(int'(vsd), 0, "R1 vsync_dbl in reset");
    chk(int'(fidi) + int'(fidd), 0, "R1 flags in reset");
    chk(int'(llast) + int'(lprev), 0, "R1 lengths in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(int'(llast) + int'(lprev) + int'(fidi) + int'(fidd), 0, "R1 first clock after reset");
    cmp_on = 1'b1;
    off = 10'd4;

    wait_strobe(); t0 = $time;
    wait_strobe();
    chk(($time - t0) / 10, HC, "R2 strobe period");
    phase = 4'd11;
    wait_strobe(); wait_strobe(); t0 = $time;
    wait_strobe();
    chk(($time - t0) / 10, HC, "R2 strobe period after phase change");

    field(300, 2, 0, 0, 0, 0);
    field(300, 2, 0, 0, 0, 0);
    npulse = 0;
    fid0 = fidi;
    field(310, 2, 0, 1, 300, 300);
    chk(int'(fidi), 1 - fid0, "R7 one toggle per field");
    chk(npulse, 2, "R8 R9 two doubled syncs per field");

    field(200, 2, 1, 1, 310, 300);
    npulse = 0;
    field(280, 60, 0, 1, 200, 310);
    chk(npulse, 2, "R4 R9 pulses in field with long sync");
    field(250, 2, 0, 1, 280, 200);
    chk(int'(llast), 280, "R4 long sync counted once");

    off = 10'd0;
    npulse = 0;
    field(262, 3, 0, 1, 250, 280);
    chk(npulse, 2, "R8 offset zero pulses");

    off = 10'd1023;
    npulse = 0;
    field(1100, 2, 0, 1, 262, 250);
    chk(npulse, 1, "R11 single pulse at saturation");
    field(100, 2, 0, 1, 1023, 262);
    chk(int'(llast), MAXL, "R6 saturated length");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule